// File: doc/BRIEF.md
# Soft-Start Reference Ramp Generator

This block produces the digital voltage reference for one step-down regulator channel, as an unsigned code in millivolts. When the channel is switched on, the code climbs from zero toward the channel's target at a fast soft-start rate. Once the target has been reached, a change of target (possible only on the variant whose target is chosen by an input) moves the code toward the new value at a slower rate, up or down. All movement happens only on a 1 µs timing tick.

The channel is on when its enable is high and the fault supervisor's force-off input is low. Dropping either condition shuts the channel down at once: the code goes to zero on the next clock with no ramp down. Each instance is built either as a selectable channel (1.8 V or 2.65 V by a select bit) or as a fixed channel whose target is a parameter (for example 3.3 V, 1.25 V or 1.8 V). The reference code, the ramp-done flag and the current target are all registered outputs.

Top module: `ssref_ramp_gen`

## Requirements
- R1: While the channel is on and no tick is present, the reference code holds its value.
- R2: After the channel turns on, each tick raises the code from zero by 18 mV; the step that would pass the target lands exactly on the target instead.
- R3: On a selectable instance, the target output is 1800 when the select input is low and 2650 when it is high, and it follows the select input one clock later.
- R4: On a fixed instance, the target output equals the fixed-target parameter and the select input has no effect on the target or the reference.
- R5: After the target has been reached once, a change of target moves the code 10 mV per tick toward the new target, up or down, ending exactly on it.
- R6: When enable is low, the code and ramp-done are zero from the next clock on, whatever the tick does; a later enable starts a new soft start from zero.
- R7: The force-off input has the same effect as enable low and overrides a high enable.
- R8: A change of target during a soft start that has not yet reached its target is followed at once at the soft-start rate of 18 mV per tick.
- R9: Ramp-done is high exactly when the channel is on and the code equals the current target; it drops on the clock the target changes away from the code.
- R10: While reset is high the reference code, ramp-done and target outputs are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_us | input | 1 | One-cycle pulse every microsecond; the only time the code moves |
| chan_en | input | 1 | Channel enable |
| sel_hi | input | 1 | Target select for the selectable variant (high = 2650 mV) |
| force_off | input | 1 | Shutdown request from the fault supervisor, overrides enable |
| ref_mv | output | CODE_W | Reference code in millivolts |
| ramp_done | output | 1 | Code equals the target while the channel is on |
| target_mv | output | CODE_W | Current target in millivolts |

## Verification
The checker watches on every cycle that the code stays put without a tick, never moves more than one soft-start step, never passes the target it was heading for, is zero after a disable or force-off, that ramp-done only ever coincides with code equal to target, and that the target follows the select input. Which of the two rates applies, the exact tick count of each ramp, and that a target change mid soft start keeps the fast rate depend on history the properties do not track; the bench's scenarios show these, by running soft starts to 1800 and 3300 mV, retargeting both ways at run time, retargeting during a soft start, and toggling the shutdown inputs against a running ramp.

// File: rtl/ssref_pkg.sv
package ssref_pkg;

  typedef enum logic [1:0] {
    PH_OFF  = 2'd0,
    PH_SOFT = 2'd1,
    PH_RUN  = 2'd2
  } ssref_phase_e;

  // One saturating move of cur toward tgt by at most stp.
  function automatic int unsigned sat_toward(int unsigned cur,
                                             int unsigned tgt,
                                             int unsigned stp);
    if (cur < tgt) begin
      return ((tgt - cur) <= stp) ? tgt : cur + stp;
    end else if (cur > tgt) begin
      return ((cur - tgt) <= stp) ? tgt : cur - stp;
    end
    return cur;
  endfunction

endpackage

// File: rtl/ssref_target_sel.sv
module ssref_target_sel #(
  parameter int unsigned CODE_W     = 12,
  parameter bit          SELECTABLE = 1'b1,
  parameter int unsigned FIXED_MV   = 3300,
  parameter int unsigned LO_MV      = 1800,
  parameter int unsigned HI_MV      = 2650
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_hi,
  output logic [CODE_W-1:0] tgt_d,
  output logic [CODE_W-1:0] tgt_q
);

  localparam logic [CODE_W-1:0] LO_CODE    = CODE_W'(LO_MV);
  localparam logic [CODE_W-1:0] HI_CODE    = CODE_W'(HI_MV);
  localparam logic [CODE_W-1:0] FIXED_CODE = CODE_W'(FIXED_MV);

  generate
    if (SELECTABLE) begin : g_sel
      assign tgt_d = sel_hi ? HI_CODE : LO_CODE;
    end else begin : g_fixed
      logic sel_unused;
      assign sel_unused = sel_hi;
      assign tgt_d      = FIXED_CODE;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) tgt_q <= '0;
    else     tgt_q <= tgt_d;
  end

endmodule

// File: rtl/ssref_phase_ctl.sv
module ssref_phase_ctl
  import ssref_pkg::*;
#(
  parameter int unsigned CODE_W        = 12,
  parameter int unsigned START_STEP_MV = 18,
  parameter int unsigned TRIM_STEP_MV  = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              active,
  input  logic              at_tgt,
  output ssref_phase_e      phase_q,
  output logic [CODE_W-1:0] step_mv
);

  localparam logic [CODE_W-1:0] START_CODE = CODE_W'(START_STEP_MV);
  localparam logic [CODE_W-1:0] TRIM_CODE  = CODE_W'(TRIM_STEP_MV);

  ssref_phase_e phase_d;

  always_comb begin
    phase_d = phase_q;
    if (!active) begin
      phase_d = PH_OFF;
    end else begin
      unique case (phase_q)
        PH_OFF:  phase_d = PH_SOFT;
        PH_SOFT: phase_d = at_tgt ? PH_RUN : PH_SOFT;
        PH_RUN:  phase_d = PH_RUN;
        default: phase_d = PH_OFF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) phase_q <= PH_OFF;
    else     phase_q <= phase_d;
  end

  assign step_mv = (phase_q == PH_RUN) ? TRIM_CODE : START_CODE;

endmodule

// File: rtl/ssref_slew_acc.sv
module ssref_slew_acc
  import ssref_pkg::*;
#(
  parameter int unsigned CODE_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              active,
  input  logic              tick_us,
  input  logic [CODE_W-1:0] tgt_q,
  input  logic [CODE_W-1:0] tgt_d,
  input  logic [CODE_W-1:0] step_mv,
  output logic [CODE_W-1:0] ref_q,
  output logic              done_q,
  output logic              at_tgt
);

  logic [CODE_W-1:0] ref_d;

  always_comb begin
    if (!active) begin
      ref_d = '0;
    end else if (tick_us) begin
      ref_d = CODE_W'(sat_toward(32'(ref_q), 32'(tgt_q), 32'(step_mv)));
    end else begin
      ref_d = ref_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_q  <= '0;
      done_q <= 1'b0;
    end else begin
      ref_q  <= ref_d;
      done_q <= active && (ref_d == tgt_d);
    end
  end

  assign at_tgt = (ref_q == tgt_q);

endmodule

// File: rtl/ssref_ramp_gen.sv
module ssref_ramp_gen
  import ssref_pkg::*;
#(
  parameter int unsigned CODE_W        = 12,
  parameter bit          SELECTABLE    = 1'b1,
  parameter int unsigned FIXED_MV      = 3300,
  parameter int unsigned LO_MV         = 1800,
  parameter int unsigned HI_MV         = 2650,
  parameter int unsigned START_STEP_MV = 18,
  parameter int unsigned TRIM_STEP_MV  = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_us,
  input  logic              chan_en,
  input  logic              sel_hi,
  input  logic              force_off,
  output logic [CODE_W-1:0] ref_mv,
  output logic              ramp_done,
  output logic [CODE_W-1:0] target_mv
);

  logic              active;
  logic [CODE_W-1:0] tgt_d;
  logic [CODE_W-1:0] tgt_q;
  logic [CODE_W-1:0] step_mv;
  logic              at_tgt;
  ssref_phase_e      phase_q;
  logic              phase_unused;

  // Force-off from the fault supervisor wins over enable.
  assign active = chan_en && !force_off;

  ssref_target_sel #(
    .CODE_W    (CODE_W),
    .SELECTABLE(SELECTABLE),
    .FIXED_MV  (FIXED_MV),
    .LO_MV     (LO_MV),
    .HI_MV     (HI_MV)
  ) target_i (
    .clk   (clk),
    .rst   (rst),
    .sel_hi(sel_hi),
    .tgt_d (tgt_d),
    .tgt_q (tgt_q)
  );

  ssref_phase_ctl #(
    .CODE_W       (CODE_W),
    .START_STEP_MV(START_STEP_MV),
    .TRIM_STEP_MV (TRIM_STEP_MV)
  ) phase_i (
    .clk    (clk),
    .rst    (rst),
    .active (active),
    .at_tgt (at_tgt),
    .phase_q(phase_q),
    .step_mv(step_mv)
  );

  assign phase_unused = ^phase_q;

  ssref_slew_acc #(
    .CODE_W(CODE_W)
  ) slew_i (
    .clk    (clk),
    .rst    (rst),
    .active (active),
    .tick_us(tick_us),
    .tgt_q  (tgt_q),
    .tgt_d  (tgt_d),
    .step_mv(step_mv),
    .ref_q  (ref_mv),
    .done_q (ramp_done),
    .at_tgt (at_tgt)
  );

  assign target_mv = tgt_q;

endmodule

// File: rtl/ssref_ramp_gen_chk.sv
module ssref_ramp_gen_chk #(
  parameter int unsigned CODE_W        = 12,
  parameter bit          SELECTABLE    = 1'b1,
  parameter int unsigned FIXED_MV      = 3300,
  parameter int unsigned LO_MV         = 1800,
  parameter int unsigned HI_MV         = 2650,
  parameter int unsigned START_STEP_MV = 18
) (
  input logic              clk,
  input logic              rst,
  input logic              tick_us,
  input logic              chan_en,
  input logic              sel_hi,
  input logic              force_off,
  input logic [CODE_W-1:0] ref_mv,
  input logic              ramp_done,
  input logic [CODE_W-1:0] target_mv
);

  a_r1_hold_without_tick: assert property (@(posedge clk) disable iff (rst)
    (!tick_us && chan_en && !force_off) |=> $stable(ref_mv));

  a_r2_step_up_bound: assert property (@(posedge clk) disable iff (rst)
    (tick_us && chan_en && !force_off) |=>
      (32'(ref_mv) <= 32'($past(ref_mv)) + START_STEP_MV));

  a_r2_no_overshoot: assert property (@(posedge clk) disable iff (rst)
    (chan_en && !force_off && ref_mv <= target_mv) |=>
      (ref_mv <= $past(target_mv)));

  a_r6_disable_zero: assert property (@(posedge clk) disable iff (rst)
    !chan_en |=> (ref_mv == '0 && !ramp_done));

  a_r7_force_zero: assert property (@(posedge clk) disable iff (rst)
    force_off |=> (ref_mv == '0 && !ramp_done));

  a_r9_done_match: assert property (@(posedge clk) disable iff (rst)
    ramp_done |-> (ref_mv == target_mv));

  generate
    if (SELECTABLE) begin : g_sel_chk
      a_r3_sel_high: assert property (@(posedge clk) disable iff (rst)
        sel_hi |=> (32'(target_mv) == HI_MV));
      a_r3_sel_low: assert property (@(posedge clk) disable iff (rst)
        !sel_hi |=> (32'(target_mv) == LO_MV));
    end else begin : g_fix_chk
      a_r4_fixed_target: assert property (@(posedge clk) disable iff (rst)
        $changed(sel_hi) |=> (32'(target_mv) == FIXED_MV));
    end
  endgenerate

endmodule

bind ssref_ramp_gen ssref_ramp_gen_chk #(
  .CODE_W       (CODE_W),
  .SELECTABLE   (SELECTABLE),
  .FIXED_MV     (FIXED_MV),
  .LO_MV        (LO_MV),
  .HI_MV        (HI_MV),
  .START_STEP_MV(START_STEP_MV)
) chk_i (
  .clk      (clk),
  .rst      (rst),
  .tick_us  (tick_us),
  .chan_en  (chan_en),
  .sel_hi   (sel_hi),
  .force_off(force_off),
  .ref_mv   (ref_mv),
  .ramp_done(ramp_done),
  .target_mv(target_mv)
);

// File: tb/ssref_ramp_gen_tb_top.sv
module ssref_ramp_gen_tb_top;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst = 1'b1, tick = 1'b0, en = 1'b0, fo = 1'b0, sel = 1'b0;
  logic [11:0] ref_a, tgt_a, ref_b, tgt_b;
  logic        done_a, done_b;

  ssref_ramp_gen #(.SELECTABLE(1'b1)) dut_i (
    .clk(clk), .rst(rst), .tick_us(tick), .chan_en(en), .sel_hi(sel),
    .force_off(fo), .ref_mv(ref_a), .ramp_done(done_a), .target_mv(tgt_a));

  ssref_ramp_gen #(.SELECTABLE(1'b0), .FIXED_MV(3300)) dut_fix_i (
    .clk(clk), .rst(rst), .tick_us(tick), .chan_en(en), .sel_hi(sel),
    .force_off(fo), .ref_mv(ref_b), .ramp_done(done_b), .target_mv(tgt_b));

  int n_vec = 0, n_bad = 0;
  bit finished = 1'b0;

  int m_ref_a = 0, m_ref_b = 0, m_tgt_a = 0;
  bit m_run_a = 1'b0, m_run_b = 1'b0, m_act = 1'b0;

  typedef struct {
    int    ra;
    bit    da;
    int    rb;
    bit    db;
    string tag;
  } exp_t;
  exp_t sb_q[$];

  task automatic check(string tag, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int toward(int c, int t, int s);
    if (c < t) return ((t - c) <= s) ? t : c + s;
    if (c > t) return ((c - t) <= s) ? t : c - s;
    return c;
  endfunction

  // Driver: one tick pulse, expected results pushed to the scoreboard.
  task automatic tick_once(string tag);
    exp_t e;
    @(negedge clk);
    tick = 1'b1;
    if (m_act) begin
      m_ref_a = toward(m_ref_a, m_tgt_a, m_run_a ? 10 : 18);
      if (m_ref_a == m_tgt_a) m_run_a = 1'b1;
      m_ref_b = toward(m_ref_b, 3300, m_run_b ? 10 : 18);
      if (m_ref_b == 3300) m_run_b = 1'b1;
    end
    e.ra  = m_ref_a;
    e.da  = m_act && (m_ref_a == m_tgt_a);
    e.rb  = m_ref_b;
    e.db  = m_act && (m_ref_b == 3300);
    e.tag = tag;
    sb_q.push_back(e);
    @(negedge clk);
    tick = 1'b0;
  endtask

  // Monitor: after every tick edge, compare against the queue head.
  initial begin
    forever begin
      @(posedge clk);
      if (tick) begin
        exp_t e;
        @(negedge clk);
        if (sb_q.size() == 0) begin
          check("scoreboard empty", 1, 0);
        end else begin
          e = sb_q.pop_front();
          check({e.tag, " ref sel"},   int'(ref_a),  e.ra);
          check({e.tag, " R9 done sel"}, int'(done_a), int'(e.da));
          check({e.tag, " ref fixed"}, int'(ref_b),  e.rb);
          check({e.tag, " R9 done fixed"}, int'(done_b), int'(e.db));
        end
      end
    end
  end

  task automatic set_sel(bit v, string tag);
    @(negedge clk);
    sel = v;
    m_tgt_a = v ? 2650 : 1800;
    @(negedge clk);
    check({tag, " R3 target sel"}, int'(tgt_a), m_tgt_a);
    check({tag, " R4 target fixed"}, int'(tgt_b), 3300);
    check({tag, " R9 done after retarget"}, int'(done_a),
          int'(m_act && (m_ref_a == m_tgt_a)));
  endtask

  task automatic set_act(bit e, bit f, string tag);
    @(negedge clk);
    en = e;
    fo = f;
    m_act = e && !f;
    if (!m_act) begin
      m_ref_a = 0; m_ref_b = 0; m_run_a = 1'b0; m_run_b = 1'b0;
    end
    @(negedge clk);
    check({tag, " ref sel"},   int'(ref_a),  m_ref_a);
    check({tag, " ref fixed"}, int'(ref_b),  m_ref_b);
    check({tag, " done sel"},  int'(done_a), int'(m_act && (m_ref_a == m_tgt_a)));
  endtask

  task automatic idle(int n, string tag);
    repeat (n) @(negedge clk);
    check({tag, " hold sel"},   int'(ref_a), m_ref_a);
    check({tag, " hold fixed"}, int'(ref_b), m_ref_b);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    // R10: reset state
    repeat (3) @(negedge clk);
    check("R10 ref", int'(ref_a), 0);
    check("R10 done", int'(done_a), 0);
    check("R10 target", int'(tgt_a), 0);
    check("R10 target fixed", int'(tgt_b), 0);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    m_tgt_a = 1800;
    check("R3 target low", int'(tgt_a), 1800);
    check("R4 target fixed", int'(tgt_b), 3300);

    // R6: ticks while disabled leave the code at zero
    repeat (3) tick_once("R6 off");

    set_act(1'b1, 1'b0, "R6 enable");
    idle(5, "R1");

    // R2: soft start, 1800 reached exactly on tick 100, 3300 on tick 184
    repeat (100) tick_once("R2");
    check("R2 sel at target", int'(ref_a), 1800);
    repeat (84) tick_once("R2");
    check("R2 fixed at target", int'(ref_b), 3300);

    // R5: run-time retarget up and down at 10 per tick
    set_sel(1'b1, "R5 up");
    repeat (85) tick_once("R5 up");
    check("R5 up end", int'(ref_a), 2650);
    idle(6, "R1");
    set_sel(1'b0, "R5 down");
    repeat (85) tick_once("R5 down");
    check("R5 down end", int'(ref_a), 1800);

    // R6: shutdown without ramp down, ticks ignored while off
    set_act(1'b0, 1'b0, "R6 disable");
    repeat (2) tick_once("R6 off");

    // R8: retarget during soft start keeps the fast rate
    set_act(1'b1, 1'b0, "R8 enable");
    repeat (50) tick_once("R8");
    set_sel(1'b1, "R8");
    repeat (100) tick_once("R8");
    check("R8 end", int'(ref_a), 2650);

    // R7: force-off overrides enable
    set_act(1'b1, 1'b1, "R7 force");
    repeat (3) tick_once("R7 force");
    set_act(1'b1, 1'b0, "R7 release");
    repeat (20) tick_once("R7 restart");
    set_sel(1'b0, "R4 sel toggle");
    repeat (10) tick_once("R4");
    set_act(1'b0, 1'b1, "R7 both");
    idle(3, "R7");

    summary();
  end

endmodule